// File: doc/BRIEF.md
# Per-Channel Circular Address Mapper

This block keeps a large set of independent circular packet queues inside one shared external memory. Each channel owns a contiguous byte region with its own start and end address and tracks two offsets within it: a read offset for the oldest stored packet and a write offset for the next free slot. A queue manager presents a channel number and a direction. The block answers one cycle later with the byte address to use, and it moves the matching offset forward by one packet slot.

Offsets wrap back to the start of the region when the next slot would reach the region end. The end address is exclusive. Every response also reports whether the channel was empty or full before the access. An access that would overrun or underrun the queue is refused, and the offsets stay as they were. A configuration port loads a channel's region bounds and clears both of its offsets. A region must hold at least two packet slots, and each channel is configured before its first access.

Top module: `chan_ring_mapper`

## Requirements
- R1: A configuration write (`cfg_we`=1) loads the start and end address of channel `cfg_ch` and sets both of its offsets to zero, so the channel is empty afterwards.
- R2: An accepted write request (`req_wr`=1) returns `rsp_addr` = region start + write offset. The address always lies in [start, end).
- R3: An accepted read request (`req_wr`=0) returns `rsp_addr` = region start + read offset.
- R4: Each accepted access moves its offset forward by 192 bytes. When offset+192 is greater than or equal to end−start, the offset becomes 0 instead.
- R5: `rsp_empty` is 1 when the read offset equals the write offset before the access. `rsp_full` is 1 when the advanced write offset would equal the read offset before the access.
- R6: A write to a full channel or a read from an empty channel sets `rsp_err`=1 and leaves both offsets unchanged. `rsp_addr` still shows the current offset's address.
- R7: `rsp_valid` is 1 exactly in the cycle after a request is accepted, and the address and flags are valid in that cycle.
- R8: When `cfg_we` and `req_valid` are both 1 in the same cycle, the configuration takes effect and the request is dropped: no response and no offset movement on any channel.
- R9: Channels are independent. Accesses to one channel do not move another channel's offsets.
- R10: A synchronous active-high `rst` clears `rsp_valid`, `rsp_err`, `rsp_full`, `rsp_empty` and `rsp_addr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load a channel descriptor |
| cfg_ch | input | 9 | Channel being configured |
| cfg_start | input | 32 | Region start byte address |
| cfg_end | input | 32 | Region end byte address (exclusive) |
| req_valid | input | 1 | Access request |
| req_wr | input | 1 | 1 = write (tail), 0 = read (head) |
| req_ch | input | 9 | Channel of the request |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_addr | output | 32 | Byte address for the access |
| rsp_err | output | 1 | Request refused (full on write, empty on read) |
| rsp_full | output | 1 | Channel was full before the access |
| rsp_empty | output | 1 | Channel was empty before the access |

## Verification
Offset state cannot be read directly. A corrupted read or write offset is seen at the ports on the very next access to that channel, either as a wrong `rsp_addr` or as wrong full and empty flags. The stimulus therefore revisits each channel after every change of state.

A refused access that still moved an offset shows up on the next read or write as a skipped slot. Wrap errors show up on the access that follows the last slot. A dropped request that leaked into the state is exposed by reading the affected channel right after the collision.

// File: rtl/ring_map_pkg.sv
package ring_map_pkg;
  localparam int ADDR_W    = 32;
  localparam int PKT_BYTES = 192;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic [ADDR_W-1:0] rd_ofs;
    logic [ADDR_W-1:0] wr_ofs;
  } ring_desc_t;
endpackage

// File: rtl/ring_desc_store.sv
module ring_desc_store
  import ring_map_pkg::*;
#(
  parameter int NUM_CH = 512,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_limit,
  input  logic [CH_W-1:0]   look_ch,
  output ring_desc_t        look_desc,
  input  logic              rd_adv_we,
  input  logic              wr_adv_we,
  input  logic [CH_W-1:0]   upd_ch,
  input  logic [ADDR_W-1:0] upd_ofs
);
  logic [ADDR_W-1:0] base_mem  [NUM_CH];
  logic [ADDR_W-1:0] limit_mem [NUM_CH];
  logic [ADDR_W-1:0] rd_mem    [NUM_CH];
  logic [ADDR_W-1:0] wr_mem    [NUM_CH];

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      base_mem[cfg_ch]  <= cfg_base;
      limit_mem[cfg_ch] <= cfg_limit;
      rd_mem[cfg_ch]    <= '0;
      wr_mem[cfg_ch]    <= '0;
    end else begin
      if (rd_adv_we) rd_mem[upd_ch] <= upd_ofs;
      if (wr_adv_we) wr_mem[upd_ch] <= upd_ofs;
    end
  end

  always_comb begin
    look_desc.base   = base_mem[look_ch];
    look_desc.limit  = limit_mem[look_ch];
    look_desc.rd_ofs = rd_mem[look_ch];
    look_desc.wr_ofs = wr_mem[look_ch];
  end

  // R8: config never coincides with an offset update; R6: at most one offset moves
  assert_single_writer_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cfg_we, rd_adv_we, wr_adv_we}));
endmodule

// File: rtl/ring_ofs_adv.sv
module ring_ofs_adv
  import ring_map_pkg::*;
(
  input  logic [ADDR_W-1:0] cur_ofs,
  input  logic [ADDR_W-1:0] span,
  output logic [ADDR_W-1:0] nxt_ofs
);
  logic [ADDR_W-1:0] stepped;
  always_comb begin
    stepped = cur_ofs + ADDR_W'(PKT_BYTES);
    nxt_ofs = (stepped >= span) ? '0 : stepped;
  end
endmodule

// File: rtl/chan_ring_mapper.sv
module chan_ring_mapper
  import ring_map_pkg::*;
#(
  parameter int NUM_CH = 512,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [ADDR_W-1:0] cfg_start,
  input  logic [ADDR_W-1:0] cfg_end,
  input  logic              req_valid,
  input  logic              req_wr,
  input  logic [CH_W-1:0]   req_ch,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_err,
  output logic              rsp_full,
  output logic              rsp_empty
);
  ring_desc_t        desc;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] adv_ofs [2];
  logic [ADDR_W-1:0] cur_ofs [2];
  logic              accept, is_full, is_empty, refuse;
  logic              rd_adv_we, wr_adv_we;
  logic [ADDR_W-1:0] upd_ofs;

  ring_desc_store #(.NUM_CH(NUM_CH)) u_store (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_ch    (cfg_ch),
    .cfg_base  (cfg_start),
    .cfg_limit (cfg_end),
    .look_ch   (req_ch),
    .look_desc (desc),
    .rd_adv_we (rd_adv_we),
    .wr_adv_we (wr_adv_we),
    .upd_ch    (req_ch),
    .upd_ofs   (upd_ofs)
  );

  assign span       = desc.limit - desc.base;
  assign cur_ofs[0] = desc.rd_ofs;
  assign cur_ofs[1] = desc.wr_ofs;

  for (genvar gi = 0; gi < 2; gi++) begin : g_adv
    ring_ofs_adv u_adv (
      .cur_ofs (cur_ofs[gi]),
      .span    (span),
      .nxt_ofs (adv_ofs[gi])
    );
  end

  always_comb begin
    accept    = req_valid && !cfg_we;
    is_empty  = (desc.rd_ofs == desc.wr_ofs);
    is_full   = (adv_ofs[1] == desc.rd_ofs);
    refuse    = req_wr ? is_full : is_empty;
    rd_adv_we = accept && !req_wr && !is_empty;
    wr_adv_we = accept &&  req_wr && !is_full;
    upd_ofs   = req_wr ? adv_ofs[1] : adv_ofs[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_err   <= 1'b0;
      rsp_full  <= 1'b0;
      rsp_empty <= 1'b0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_addr  <= desc.base + (req_wr ? desc.wr_ofs : desc.rd_ofs);
        rsp_err   <= refuse;
        rsp_full  <= is_full;
        rsp_empty <= is_empty;
      end
    end
  end

  // R7: one response per accepted request, on the following cycle
  assert_resp_latency_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !cfg_we) |=> rsp_valid);

  // R8: a request colliding with configuration gives no response
  assert_cfg_drops_req_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cfg_we) |=> !rsp_valid);

  // R2: an accepted access address stays inside its channel region
  assert_addr_in_region_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_err) |->
      (rsp_addr >= $past(desc.base) && rsp_addr < $past(desc.limit)));

  // R6: a refused write was against a full channel
  assert_wr_refuse_full_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err && $past(req_wr)) |-> rsp_full);
endmodule

// File: tb/chan_ring_mapper_tb.sv
module chan_ring_mapper_tb;
  localparam int CH_W = 9;
  localparam int NV   = 15;
  localparam logic [31:0] A3 = 32'h0000_1000;
  localparam logic [31:0] A5 = 32'h0008_0000;

  // vector: {wr, ch[8:0], addr[31:0], err, full, empty} = 45 bits
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 9'd3,   A3,            1'b1, 1'b0, 1'b1},  // R1 R6 fresh channel empty
    {1'b1, 9'd3,   A3,            1'b0, 1'b0, 1'b1},  // R2
    {1'b1, 9'd3,   A3 + 32'd192,  1'b0, 1'b0, 1'b0},  // R4
    {1'b1, 9'd3,   A3 + 32'd384,  1'b0, 1'b0, 1'b0},
    {1'b1, 9'd3,   A3 + 32'd576,  1'b1, 1'b1, 1'b0},  // R5 R6 full refused
    {1'b0, 9'd3,   A3,            1'b0, 1'b1, 1'b0},  // R3
    {1'b1, 9'd3,   A3 + 32'd576,  1'b0, 1'b0, 1'b0},  // R6 unchanged tail, wraps
    {1'b0, 9'd500, A5,            1'b1, 1'b0, 1'b1},  // R9
    {1'b1, 9'd500, A5,            1'b0, 1'b0, 1'b1},
    {1'b0, 9'd3,   A3 + 32'd192,  1'b0, 1'b1, 1'b0},  // R4 R5 wrapped tail
    {1'b0, 9'd3,   A3 + 32'd384,  1'b0, 1'b0, 1'b0},
    {1'b0, 9'd3,   A3 + 32'd576,  1'b0, 1'b0, 1'b0},  // R4 head wraps
    {1'b0, 9'd3,   A3,            1'b1, 1'b0, 1'b1},  // R5 empty again
    {1'b0, 9'd500, A5,            1'b0, 1'b0, 1'b0},  // R9
    {1'b0, 9'd500, A5 + 32'd192,  1'b1, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst;
  logic cfg_we, req_valid, req_wr;
  logic [CH_W-1:0] cfg_ch, req_ch;
  logic [31:0] cfg_start, cfg_end;
  logic rsp_valid, rsp_err, rsp_full, rsp_empty;
  logic [31:0] rsp_addr;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  chan_ring_mapper u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_start(cfg_start), .cfg_end(cfg_end), .req_valid(req_valid),
    .req_wr(req_wr), .req_ch(req_ch), .rsp_valid(rsp_valid),
    .rsp_addr(rsp_addr), .rsp_err(rsp_err), .rsp_full(rsp_full),
    .rsp_empty(rsp_empty)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic configure(input logic [8:0] ch, input logic [31:0] s, input logic [31:0] e);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = ch; cfg_start = s; cfg_end = e;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input string req, input logic wr, input logic [8:0] ch,
                        input logic [31:0] ea, input logic ee, input logic ef, input logic em);
    @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_ch = ch;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R7 valid"}, 64'(rsp_valid), 64'(1'b1));
    check({req, " addr"},  64'(rsp_addr),  64'(ea));
    check({req, " err"},   64'(rsp_err),   64'(ee));
    check({req, " full"},  64'(rsp_full),  64'(ef));
    check({req, " empty"}, 64'(rsp_empty), 64'(em));
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_ch = '0; cfg_start = '0; cfg_end = '0;
    req_valid = 1'b0; req_wr = 1'b0; req_ch = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid", 64'(rsp_valid), 64'd0);
    check("R10 addr",  64'(rsp_addr),  64'd0);
    check("R10 flags", 64'({rsp_err, rsp_full, rsp_empty}), 64'd0);
    rst = 1'b0;

    configure(9'd3,   A3, A3 + 32'd768);  // R1 four slots
    configure(9'd500, A5, A5 + 32'd576);
    for (int i = 0; i < NV; i++) begin
      access($sformatf("vec%0d", i), VEC[i][44], VEC[i][43:35], VEC[i][34:3],
             VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R8: configuration collides with a write to channel 500
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 9'd3; cfg_start = 32'h2000; cfg_end = 32'h2000 + 32'd384;
    req_valid = 1'b1; req_wr = 1'b1; req_ch = 9'd500;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R8 no response", 64'(rsp_valid), 64'd0);
    access("R8 dropped write left ch500 empty", 1'b0, 9'd500, A5 + 32'd192, 1'b1, 1'b0, 1'b1);
    // R1 reconfigured two-slot region
    access("R1 reconfig read empty", 1'b0, 9'd3, 32'h2000, 1'b1, 1'b0, 1'b1);
    access("R2 write new region", 1'b1, 9'd3, 32'h2000, 1'b0, 1'b0, 1'b1);
    access("R4 R6 two-slot full", 1'b1, 9'd3, 32'h20C0, 1'b1, 1'b1, 1'b0);
    access("R3 read new region", 1'b0, 9'd3, 32'h2000, 1'b0, 1'b1, 1'b0);

    // R10 reset clears outputs after activity
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R10 reset after use", 64'({rsp_valid, rsp_err, rsp_full, rsp_empty}), 64'd0);
    check("R10 addr after use", 64'(rsp_addr), 64'd0);
    rst = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule